// File: doc/BRIEF.md
# Programmable High/Low Cycle Clock Generator

This block drives one output with a clock-like waveform. The high time and the low time are set separately, and the waveform runs for a set number of complete cycles. A single period word holds both durations: the high time sits in the upper half and the low time in the lower half, each counted in system clocks.

Writing a cycle count starts a burst. Each cycle is a high phase followed by a low phase. The count names whole cycles, so software never doubles it to reach a number of clock pulses. When the burst ends, the output rests low and a done flag rises.

Typical uses are clocking a neighbouring serial shifter, PWM with a known number of periods, and single pulses of a chosen width (a count of one).

Top module: `pcg_top`

## Requirements
- R1: Each high phase lasts exactly the number of system clocks held in period bits 31:16.
- R2: Each low phase lasts exactly the number of system clocks held in period bits 15:0.
- R3: A duration field of zero yields a phase of exactly one clock, so the waveform never stalls.
- R4: A count of N yields exactly N high-then-low cycles, with no doubling of N.
- R5: A count write with N greater than zero makes `pin_out` high in the first cycle after the edge that takes the write.
- R6: At the edge that ends the last low phase, `done` becomes 1 and `pin_out` stays 0 from then on. `done` is 0 from the cycle after any nonzero count write until that edge.
- R7: A count write of zero produces no high cycle, and `done` is 1 in the cycle after the write.
- R8: While `rst` is high at an edge, `pin_out` is 0 and `done` is 0 after that edge, and any burst in progress is abandoned.
- R9: A count write during a burst abandons the burst and starts a fresh one, beginning with a high phase in the next cycle.
- R10: The period may be rewritten at any time. A phase that begins at a later edge than the write takes its duration from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_we | input | 1 | Write strobe for the period word |
| period_wdata | input | 32 | High duration in bits 31:16, low duration in bits 15:0 |
| count_we | input | 1 | Write strobe for the cycle count; starts a burst |
| count_wdata | input | 32 | Number of complete high-then-low cycles |
| pin_out | output | 1 | Generated waveform |
| done | output | 1 | High once a burst has finished |

## Verification
Let k be the edge that takes a nonzero count write. Then `pin_out` is high from the sample just after edge k, and the expected level at sample j is high when j modulo (H+L) is below H, where H and L are the durations after the zero-to-one rule. The bench samples on falling edges, starting from the one that follows edge k. It compares every sample of the burst against that formula. It then checks `done` and the resting low level one sample after the last cycle, since both are set by the edge that closes the final low phase. A zero count, a reset and a restart each have their effect one sample after their edge, and each is checked at exactly that sample.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    // Width of one duration field; the period word is twice this width.
    parameter int DUR_W    = 16;
    parameter int PERIOD_W = 2 * DUR_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Packed with the high field first so it occupies the upper bits.
    typedef struct packed {
        logic [DUR_W-1:0] hi_len;
        logic [DUR_W-1:0] lo_len;
    } period_t;

    // Timer reload for a phase of the given length; a zero length acts as one.
    function automatic logic [DUR_W-1:0] reload_of(input logic [DUR_W-1:0] len);
        logic [DUR_W-1:0] r;
        if (len == '0) r = '0;
        else           r = len - 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pcg_period_reg.sv
module pcg_period_reg
    import pcg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [PERIOD_W-1:0] wdata,
    output period_t             q
);

    period_t q_r;

    always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (we) q_r <= period_t'(wdata);
    end

    assign q = q_r;

    // A written value is visible on the next cycle.
    AST_PERIOD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == period_t'($past(wdata))));  // R10

endmodule

// File: rtl/pcg_phase_timer.sv
module pcg_phase_timer
    import pcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DUR_W-1:0] load_val,
    output logic             expired
);

    logic [DUR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // Without a load the timer never wraps below zero.
    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);  // R3

    // A loaded value counts down by one per clock.
    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));  // R1

endmodule

// File: rtl/pcg_cycle_ctrl.sv
module pcg_cycle_ctrl
    import pcg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_count,
    input  logic             expired,
    output phase_e           phase,
    output logic             load,
    output logic             load_hi,
    output logic             done
);

    phase_e           phase_r, phase_n;
    logic [CNT_W-1:0] remain_r, remain_n;
    logic             done_r, done_n;

    always_comb begin
        phase_n  = phase_r;
        remain_n = remain_r;
        done_n   = done_r;
        load     = 1'b0;
        load_hi  = 1'b0;
        if (start) begin
            if (start_count == '0) begin
                phase_n  = PH_IDLE;
                remain_n = '0;
                done_n   = 1'b1;
            end else begin
                phase_n  = PH_HIGH;
                remain_n = start_count;
                done_n   = 1'b0;
                load     = 1'b1;
                load_hi  = 1'b1;
            end
        end else begin
            case (phase_r)
                PH_HIGH: begin
                    if (expired) begin
                        phase_n = PH_LOW;
                        load    = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (expired) begin
                        if (remain_r == CNT_W'(1)) begin
                            phase_n  = PH_IDLE;
                            remain_n = '0;
                            done_n   = 1'b1;
                        end else begin
                            phase_n  = PH_HIGH;
                            remain_n = remain_r - 1'b1;
                            load     = 1'b1;
                            load_hi  = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_r  <= PH_IDLE;
            remain_r <= '0;
            done_r   <= 1'b0;
        end else begin
            phase_r  <= phase_n;
            remain_r <= remain_n;
            done_r   <= done_n;
        end
    end

    assign phase = phase_r;
    assign done  = done_r;

    // An active burst always has at least one cycle left.
    AST_ACTIVE_HAS_REMAIN: assert property (@(posedge clk) disable iff (rst)
        (phase_r != PH_IDLE) |-> (remain_r != '0));  // R4

    // Done and an active phase never coexist.
    AST_DONE_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_r |-> (phase_r == PH_IDLE));  // R6

    // A low phase is always followed by a high phase or the idle state, never by another low.
    AST_LOW_EXIT: assert property (@(posedge clk) disable iff (rst)
        (phase_r == PH_LOW && expired && !start) |=> (phase_r != PH_LOW));  // R2

endmodule

// File: rtl/pcg_top.sv
module pcg_top
    import pcg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                period_we,
    input  logic [PERIOD_W-1:0] period_wdata,
    input  logic                count_we,
    input  logic [CNT_W-1:0]    count_wdata,
    output logic                pin_out,
    output logic                done
);

    period_t          period;
    phase_e           phase;
    logic             tmr_load;
    logic             tmr_load_hi;
    logic             tmr_expired;
    logic [DUR_W-1:0] tmr_val;

    pcg_period_reg u_period (
        .clk   (clk),
        .rst   (rst),
        .we    (period_we),
        .wdata (period_wdata),
        .q     (period)
    );

    pcg_cycle_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (count_we),
        .start_count (count_wdata),
        .expired     (tmr_expired),
        .phase       (phase),
        .load        (tmr_load),
        .load_hi     (tmr_load_hi),
        .done        (done)
    );

    assign tmr_val = tmr_load_hi ? reload_of(period.hi_len) : reload_of(period.lo_len);

    pcg_phase_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign pin_out = (phase == PH_HIGH);

    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        (count_we && count_wdata != '0) |=> (pin_out && !done));  // R5

    AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (rst)
        (count_we && count_wdata == '0) |=> (done && !pin_out));  // R7

    AST_DONE_REST_LOW: assert property (@(posedge clk) disable iff (rst)
        done |-> !pin_out);  // R6

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!pin_out && !done));  // R8

endmodule

// File: tb/pcg_top_tb.sv
module pcg_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        period_we = 1'b0;
    logic [31:0] period_wdata = '0;
    logic        count_we = 1'b0;
    logic [31:0] count_wdata = '0;
    logic        pin_out;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pcg_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .count_we     (count_we),
        .count_wdata  (count_wdata),
        .pin_out      (pin_out),
        .done         (done)
    );

    function automatic int eff_len(input int raw);
        return (raw == 0) ? 1 : raw;
    endfunction

    function automatic logic exp_level(input int j, input int h, input int l);
        return ((j % (h + l)) < h);
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic write_period(input int h, input int l);
        @(negedge clk);
        period_we    = 1'b1;
        period_wdata = {h[15:0], l[15:0]};
        @(negedge clk);
        period_we    = 1'b0;
    endtask

    // Starts a burst and checks every sample of it plus the resting state.
    task automatic run_burst(input int h_raw, input int l_raw, input int n, input string req);
        int h, l, total, bad_j;
        logic bad_act, bad_exp;
        h = eff_len(h_raw);
        l = eff_len(l_raw);
        total = n * (h + l);
        bad_j = -1;
        bad_act = 1'b0;
        bad_exp = 1'b0;
        @(negedge clk);
        count_we    = 1'b1;
        count_wdata = n;
        @(negedge clk);
        count_we    = 1'b0;
        if (total > 0) check("R6", done, 1'b0, "done low during burst");
        for (int j = 0; j < total; j++) begin
            if (j > 0) @(negedge clk);
            if (bad_j < 0 && pin_out !== exp_level(j, h, l)) begin
                bad_j   = j;
                bad_act = pin_out;
                bad_exp = exp_level(j, h, l);
            end
        end
        n_tests++;
        if (bad_j >= 0) begin
            n_fail++;
            $display("FAIL %s waveform H=%0d L=%0d N=%0d sample %0d: actual %0b expected %0b",
                     req, h_raw, l_raw, n, bad_j, bad_act, bad_exp);
        end
        if (total > 0) @(negedge clk);
        check("R6", done, 1'b1, "done after burst");
        check("R6", pin_out, 1'b0, "rest low after burst");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int h, l, n;
        void'($urandom(32'd1997));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check("R8", pin_out, 1'b0, "pin after reset");
        check("R8", done, 1'b0, "done after reset");

        // R1 R2 directed widths, single and multiple cycles (R4)
        write_period(3, 2);
        run_burst(3, 2, 1, "R1");
        write_period(1, 1);
        run_burst(1, 1, 4, "R4");
        write_period(2, 7);
        run_burst(2, 7, 3, "R2");
        // R3: zero fields act as one clock
        write_period(0, 0);
        run_burst(0, 0, 3, "R3");
        write_period(0, 4);
        run_burst(0, 4, 2, "R3");

        // R7: zero count gives no pulse
        write_period(3, 3);
        run_burst(3, 3, 0, "R7");

        // R5: output high right after the count write edge
        @(negedge clk);
        count_we = 1'b1; count_wdata = 2;
        @(negedge clk);
        count_we = 1'b0;
        check("R5", pin_out, 1'b1, "first sample after start");
        repeat (15) @(negedge clk);

        // R9: restart during a running burst
        write_period(4, 4);
        @(negedge clk);
        count_we = 1'b1; count_wdata = 3;
        @(negedge clk);
        count_we = 1'b0;
        repeat (5) @(negedge clk);
        check("R9", pin_out, 1'b0, "mid-burst low phase before restart");
        run_burst(4, 4, 2, "R9");

        // R10: period rewritten during a high phase affects the next low phase
        write_period(5, 2);
        @(negedge clk);
        count_we = 1'b1; count_wdata = 1;
        @(negedge clk);
        count_we = 1'b0;
        begin
            int hw, lw;
            hw = 0; lw = 0;
            for (int j = 0; j < 12; j++) begin
                if (j == 1) period_we = 1'b1;
                if (j == 1) period_wdata = {16'd5, 16'd3};
                if (j == 2) period_we = 1'b0;
                if (pin_out) hw++;
                else if (!done) lw++;
                @(negedge clk);
            end
            n_tests++;
            if (hw != 5 || lw != 3) begin
                n_fail++;
                $display("FAIL R10 widths after rewrite: actual %0d/%0d expected 5/3", hw, lw);
            end
        end

        // R8: reset abandons a burst
        write_period(3, 3);
        @(negedge clk);
        count_we = 1'b1; count_wdata = 5;
        @(negedge clk);
        count_we = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8", pin_out, 1'b0, "pin after mid-burst reset");
        check("R8", done, 1'b0, "done after mid-burst reset");
        rst = 1'b0;
        @(negedge clk);
        check("R8", pin_out, 1'b0, "pin stays low after reset release");

        // Random settings mixed in
        for (int k = 0; k < 24; k++) begin
            h = $urandom_range(0, 6);
            l = $urandom_range(0, 6);
            n = $urandom_range(1, 5);
            write_period(h, l);
            run_burst(h, l, n, "R4");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule